// File: doc/BRIEF.md
# Timer Comparator Channel

This block is one compare channel of an event timer. It sits beside a free-running main counter that it does not own. It keeps its own control register, comparator and hidden period register, and it raises a one-cycle fire strobe toward an interrupt router when the counter reaches the comparator. Software reaches the registers through writes one bus word wide. A strobe bit selects the lower or the upper half of the comparator. The control register and the comparator are returned on readback outputs.

The channel has two modes. In one-shot mode it fires once per programmed comparator value. In periodic mode it reloads itself by adding the hidden period to the comparator after each match. A 32-bit mode narrows the channel to the low half of the counter, so that a 64-bit timer can drive 32-bit software. In 32-bit one-shot mode the channel also fires when the low half of the counter rolls over. Every "has the counter passed the comparator" decision uses the sign of the wrapped difference. Comparisons therefore stay correct across counter wraparound.

Top module: `tmr_chan`

## Requirements
- R1: After reset the comparator reads all ones, the hidden period is zero, `fire_o` is low, and `cfg_o` reads the route mask parameter in bits 63:32, ones in bit 4 (periodic capable) and bit 5 (64-bit capable), and zeros elsewhere. The writable control field is bits 3:0: bit 0 channel enable, bit 1 periodic, bit 2 set-value, bit 3 32-bit mode.
- R2: In one-shot mode an armed channel fires once when the counter reaches the comparator, and does not fire again while the counter moves on.
- R3: In periodic mode a comparator write (`cmp_wr_i[0]` low half, `cmp_wr_i[1]` high half) changes the comparator only when set-value is 1. The hidden period half is written in every case, and set-value reads 0 after any comparator write.
- R4: In one-shot mode a comparator write replaces that comparator half directly and re-arms the channel for another fire.
- R5: In periodic mode with a non-zero period, each cycle in which the counter has reached the comparator adds the period to the comparator, until the comparator lies strictly ahead of the counter. A catch-up run of several such additions gives a single fire.
- R6: The top bit of a value stored as period is forced to 0: bit 63 on an upper-half write, and bit 31 on a lower-half write in 32-bit mode.
- R7: Writing control with bit 3 set clears the upper halves of the comparator and period. While in 32-bit mode, upper-half comparator writes store zeros.
- R8: The channel treats the counter as having reached the comparator when the wrapped difference counter minus comparator is non-negative as a signed number. In 32-bit mode this uses only the low 32 bits of both values, and otherwise all 64 bits.
- R9: In 32-bit one-shot mode an armed channel that has not yet fired also fires when the low 32 bits of the counter step from all ones to zero.
- R10: The channel is armed by a rising edge of the enable bit while `glb_en_i` is high, or by a rise of `glb_en_i` while the enable bit is set. A falling edge of the enable bit, or a low `glb_en_i`, disarms it.
- R11: `fire_o` is registered. It goes high for one cycle, directly after the clock edge at which a match or wrap was sampled with `glb_en_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 64 | Main counter value |
| glb_en_i | input | 1 | Global timer enable |
| cfg_wr_i | input | 1 | Write strobe for the control field |
| cmp_wr_i | input | 2 | Comparator write strobes, bit 0 lower half, bit 1 upper half |
| wdata_i | input | 32 | Write data |
| cfg_o | output | 64 | Control and capability readback |
| cmp_o | output | 64 | Comparator readback |
| fire_o | output | 1 | One-cycle fire strobe |

## Verification
Register writes show on `cfg_o` and `cmp_o` directly after the edge that samples the strobe. A comparator advance shows after the edge that samples the match. A fire shows on `fire_o` after that same edge and is gone one edge later. Arming costs one edge, so a counter value that already matches fires one edge after the arming edge. The bench drives inputs a quarter period after a rising edge and samples the outputs at the same point after the next edge. Each check therefore sees the result of exactly the edges it has counted.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

   // Writable control field, bit 0 = enable ... bit 3 = 32-bit mode
   typedef struct packed {
      logic narrow;
      logic setval;
      logic periodic;
      logic en;
   } chan_ctrl_t;

   localparam int CTRL_W       = 4;
   localparam int CAP_PER_BIT  = 4;
   localparam int CAP_WIDE_BIT = 5;

endpackage

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int BUS_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic [CNT_W/BUS_W-1:0] cmp_wr,
   input  logic [BUS_W-1:0]       wdata,
   input  logic                   adv,
   output chan_ctrl_t             ctrl,
   output logic [CNT_W-1:0]       cmp,
   output logic [CNT_W-1:0]       period,
   output logic                   en_rise,
   output logic                   en_fall
);

   localparam int NHALF = CNT_W / BUS_W;

   chan_ctrl_t       wr_ctrl;
   logic             any_cmp_wr;
   logic             cmp_upd;
   logic [CNT_W-1:0] sum_w;
   logic [BUS_W-1:0] sum_n;

   assign wr_ctrl    = chan_ctrl_t'(wdata[CTRL_W-1:0]);
   assign any_cmp_wr = |cmp_wr;
   assign cmp_upd    = !ctrl.periodic || ctrl.setval;
   assign en_rise    = cfg_wr && !ctrl.en && wr_ctrl.en;
   assign en_fall    = cfg_wr && ctrl.en && !wr_ctrl.en;
   assign sum_w      = cmp + period;
   assign sum_n      = cmp[BUS_W-1:0] + period[BUS_W-1:0];

   // control field: a config write wins over the set-value self-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (cfg_wr) begin
         ctrl <= wr_ctrl;
      end else if (any_cmp_wr) begin
         ctrl.setval <= 1'b0;
      end
   end

   // one storage lane per bus-wide slice of comparator and period
   for (genvar h = 0; h < NHALF; h++) begin : g_lane
      localparam bit TOP  = (h == NHALF - 1);
      localparam bit BASE = (h == 0);

      logic [BUS_W-1:0] cmp_q;
      logic [BUS_W-1:0] per_q;
      logic [BUS_W-1:0] cmp_d;
      logic [BUS_W-1:0] per_d;
      logic [BUS_W-1:0] adv_d;

      always_comb begin
         cmp_d = (ctrl.narrow && !BASE) ? '0 : wdata;
         per_d = cmp_d;
         if (TOP || (BASE && ctrl.narrow)) begin
            per_d[BUS_W-1] = 1'b0;
         end
         if (ctrl.narrow) begin
            adv_d = BASE ? sum_n : '0;
         end else begin
            adv_d = sum_w[h*BUS_W +: BUS_W];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_q <= '1;
            per_q <= '0;
         end else if (cfg_wr && wr_ctrl.narrow && !BASE) begin
            cmp_q <= '0;
            per_q <= '0;
         end else if (cmp_wr[h]) begin
            if (cmp_upd) begin
               cmp_q <= cmp_d;
            end
            per_q <= per_d;
         end else if (adv && !any_cmp_wr) begin
            cmp_q <= adv_d;
         end
      end

      assign cmp[h*BUS_W +: BUS_W]    = cmp_q;
      assign period[h*BUS_W +: BUS_W] = per_q;
   end

endmodule

// File: rtl/tmr_chan_cmp.sv
module tmr_chan_cmp #(
   parameter int CNT_W = 64,
   parameter int BUS_W = 32
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             narrow,
   output logic             reached
);

   logic [CNT_W-1:0] diff_w;
   logic [BUS_W-1:0] diff_n;

   // wrapped difference; its sign says which value is ahead
   assign diff_w  = cnt - cmp;
   assign diff_n  = cnt[BUS_W-1:0] - cmp[BUS_W-1:0];
   assign reached = narrow ? !diff_n[BUS_W-1] : !diff_w[CNT_W-1];

endmodule

// File: rtl/tmr_chan_wrap.sv
module tmr_chan_wrap #(
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] cnt_lo,
   output logic             wrap_ev
);

   logic top_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= 1'b0;
      end else begin
         top_q <= &cnt_lo;
      end
   end

   assign wrap_ev = top_q && (cnt_lo == '0);

endmodule

// File: rtl/tmr_chan_fire.sv
module tmr_chan_fire (
   input  logic clk,
   input  logic rst_n,
   input  logic glb_en,
   input  logic ctrl_en,
   input  logic periodic,
   input  logic narrow,
   input  logic period_nz,
   input  logic en_rise,
   input  logic en_fall,
   input  logic cmp_wr_any,
   input  logic reached,
   input  logic wrap_ev,
   output logic adv,
   output logic fire
);

   logic armed;
   logic spent;
   logic lag;
   logic glb_q;
   logic arm_ev;
   logic live;
   logic run_per;
   logic hit;
   logic wrap_hit;
   logic fire_d;

   assign arm_ev   = (en_rise && glb_en) || (glb_en && !glb_q && ctrl_en && !en_fall);
   assign live     = armed && glb_en;
   assign run_per  = periodic && period_nz;
   assign hit      = live && reached && !spent;
   assign adv      = hit && run_per;
   assign wrap_hit = live && !spent && narrow && !periodic && wrap_ev;
   assign fire_d   = (hit && !(run_per && lag)) || wrap_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_q <= 1'b0;
         armed <= 1'b0;
         spent <= 1'b0;
         lag   <= 1'b0;
         fire  <= 1'b0;
      end else begin
         glb_q <= glb_en;
         if (!glb_en || en_fall) begin
            armed <= 1'b0;
         end else if (arm_ev) begin
            armed <= 1'b1;
         end
         if (cmp_wr_any || arm_ev) begin
            spent <= 1'b0;
         end else if (hit && !run_per) begin
            spent <= 1'b1;
         end
         lag  <= adv;
         fire <= fire_d;
      end
   end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_chan_pkg::*;
#(
   parameter int          CNT_W     = 64,
   parameter int          BUS_W     = 32,
   parameter logic [31:0] ROUTE_CAP = 32'h0000_0A04
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W-1:0]       cnt_i,
   input  logic                   glb_en_i,
   input  logic                   cfg_wr_i,
   input  logic [CNT_W/BUS_W-1:0] cmp_wr_i,
   input  logic [BUS_W-1:0]       wdata_i,
   output logic [CNT_W-1:0]       cfg_o,
   output logic [CNT_W-1:0]       cmp_o,
   output logic                   fire_o
);

   localparam int UPPER_W = CNT_W - BUS_W;

   if (BUS_W < 8) begin : g_bad_bus
      $error("tmr_chan: BUS_W must hold the control and capability bits");
   end
   if ((CNT_W % BUS_W) != 0 || (CNT_W / BUS_W) < 2) begin : g_bad_cnt
      $error("tmr_chan: CNT_W must be a multiple of BUS_W, at least two lanes");
   end

   chan_ctrl_t       ctrl_w;
   logic [CNT_W-1:0] period_w;
   logic             en_rise_w;
   logic             en_fall_w;
   logic             adv_w;
   logic             reached_w;
   logic             wrap_w;
   logic [BUS_W-1:0] cfg_lo;

   tmr_chan_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr_i),
      .cmp_wr  (cmp_wr_i),
      .wdata   (wdata_i),
      .adv     (adv_w),
      .ctrl    (ctrl_w),
      .cmp     (cmp_o),
      .period  (period_w),
      .en_rise (en_rise_w),
      .en_fall (en_fall_w)
   );

   tmr_chan_cmp #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cmp (
      .cnt     (cnt_i),
      .cmp     (cmp_o),
      .narrow  (ctrl_w.narrow),
      .reached (reached_w)
   );

   tmr_chan_wrap #(.BUS_W(BUS_W)) u_wrap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_lo  (cnt_i[BUS_W-1:0]),
      .wrap_ev (wrap_w)
   );

   tmr_chan_fire u_fire (
      .clk        (clk),
      .rst_n      (rst_n),
      .glb_en     (glb_en_i),
      .ctrl_en    (ctrl_w.en),
      .periodic   (ctrl_w.periodic),
      .narrow     (ctrl_w.narrow),
      .period_nz  (|period_w),
      .en_rise    (en_rise_w),
      .en_fall    (en_fall_w),
      .cmp_wr_any (|cmp_wr_i),
      .reached    (reached_w),
      .wrap_ev    (wrap_w),
      .adv        (adv_w),
      .fire       (fire_o)
   );

   always_comb begin
      cfg_lo               = '0;
      cfg_lo[CTRL_W-1:0]   = ctrl_w;
      cfg_lo[CAP_PER_BIT]  = 1'b1;
      cfg_lo[CAP_WIDE_BIT] = 1'b1;
   end

   assign cfg_o = {UPPER_W'(ROUTE_CAP), cfg_lo};

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int BUS_W = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   glb_en_i,
   input logic                   cfg_wr_i,
   input logic [CNT_W/BUS_W-1:0] cmp_wr_i,
   input logic [BUS_W-1:0]       wdata_i,
   input logic [CNT_W-1:0]       cmp_o,
   input logic                   fire_o,
   input chan_ctrl_t             ctrl_w,
   input logic [CNT_W-1:0]       period_w,
   input logic                   adv_w
);

   // R5
   adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_w && !cfg_wr_i && cmp_wr_i == '0 && !ctrl_w.narrow)
      |=> (cmp_o == $past(cmp_o) + $past(period_w)));

   // R6
   per_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_w[CNT_W-1] == 1'b0);

   // R7
   narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_w.narrow |-> (cmp_o[CNT_W-1:BUS_W] == '0 && period_w[CNT_W-1:BUS_W] == '0));

   // R3
   setval_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_wr_i != '0 && !cfg_wr_i) |=> !ctrl_w.setval);

   // R3
   cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_wr_i != '0 && !cfg_wr_i && ctrl_w.periodic && !ctrl_w.setval)
      |=> $stable(cmp_o));

   // R10
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && ctrl_w.en && !wdata_i[0]) |=> ##1 !fire_o);

   // R11
   fire_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> $past(glb_en_i));

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .glb_en_i (glb_en_i),
   .cfg_wr_i (cfg_wr_i),
   .cmp_wr_i (cmp_wr_i),
   .wdata_i  (wdata_i),
   .cmp_o    (cmp_o),
   .fire_o   (fire_o),
   .ctrl_w   (ctrl_w),
   .period_w (period_w),
   .adv_w    (adv_w)
);

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = '0;
   logic        glb_en = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cmp_wr = '0;
   logic [31:0] wdata = '0;
   logic [63:0] cfg_o;
   logic [63:0] cmp_o;
   logic        fire_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tmr_chan u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_i    (cnt),
      .glb_en_i (glb_en),
      .cfg_wr_i (cfg_wr),
      .cmp_wr_i (cmp_wr),
      .wdata_i  (wdata),
      .cfg_o    (cfg_o),
      .cmp_o    (cmp_o),
      .fire_o   (fire_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic wr_cfg(input logic [31:0] v);
      cfg_wr = 1'b1;
      wdata  = v;
      step();
      cfg_wr = 1'b0;
   endtask

   task automatic wr_cmp(input int h, input logic [31:0] v);
      cmp_wr[h] = 1'b1;
      wdata     = v;
      step();
      cmp_wr    = '0;
   endtask

   task automatic t_reset();
      chk("R1 cfg reset", cfg_o, 64'h0000_0A04_0000_0030);
      chk("R1 cmp reset", cmp_o, '1);
      chk("R1 fire reset", {63'd0, fire_o}, 64'd0);
   endtask

   task automatic t_oneshot();
      glb_en = 1'b1;
      cnt = 64'd0;
      wr_cmp(0, 32'd100);
      wr_cmp(1, 32'd0);
      chk("R4 direct write", cmp_o, 64'd100);
      wr_cfg(32'h1);
      chk("R1 enable bit", cfg_o[3:0], 64'h1);
      cnt = 64'd99;  step();
      chk("R2 before match", {63'd0, fire_o}, 64'd0);
      cnt = 64'd100; step();
      chk("R2 R11 match fire", {63'd0, fire_o}, 64'd1);
      cnt = 64'd101; step();
      chk("R11 single cycle", {63'd0, fire_o}, 64'd0);
      cnt = 64'd200; step();
      chk("R2 no refire", {63'd0, fire_o}, 64'd0);
      wr_cmp(0, 32'd300);
      step();
      chk("R4 no early fire", {63'd0, fire_o}, 64'd0);
      cnt = 64'd300; step();
      chk("R4 rearmed fire", {63'd0, fire_o}, 64'd1);
      // signed 64-bit difference: counter far ahead is treated as behind
      cnt = 64'h8000_0000_0000_0010;
      wr_cmp(0, 32'd5);
      step(); step();
      chk("R8 wide sign", {63'd0, fire_o}, 64'd0);
      wr_cfg(32'h0);
   endtask

   task automatic t_periodic();
      int nfire;
      wr_cfg(32'h6);
      wr_cmp(0, 32'd20);
      chk("R3 setval write", cmp_o, 64'd20);
      chk("R3 setval clear", cfg_o[2], 64'd0);
      wr_cmp(1, 32'd0);
      wr_cmp(0, 32'd7);
      chk("R3 gated write", cmp_o, 64'd20);
      cnt = 64'd19;
      wr_cfg(32'h3);
      step();
      chk("R5 before match", {63'd0, fire_o}, 64'd0);
      cnt = 64'd20; step();
      chk("R5 match fire", {63'd0, fire_o}, 64'd1);
      chk("R5 advance", cmp_o, 64'd27);
      cnt = 64'd21; step();
      chk("R5 one pulse", {63'd0, fire_o}, 64'd0);
      cnt = 64'd50;
      nfire = 0;
      for (int i = 0; i < 5; i++) begin
         step();
         nfire += int'(fire_o);
      end
      chk("R5 catch-up fires", 64'(nfire), 64'd1);
      chk("R5 strictly ahead", cmp_o, 64'd55);
   endtask

   task automatic t_period_msb();
      wr_cfg(32'h6);
      wr_cmp(0, 32'h10);
      wr_cmp(1, 32'h8000_0000);
      chk("R6 cmp kept", cmp_o, 64'h10);
      cnt = 64'd0;
      wr_cfg(32'h3);
      cnt = 64'h10; step();
      chk("R6 wide fire", {63'd0, fire_o}, 64'd1);
      chk("R6 wide msb cleared", cmp_o, 64'h20);
   endtask

   task automatic t_narrow();
      wr_cfg(32'h6);
      wr_cmp(1, 32'h1234);
      chk("R3 upper setval", cmp_o, 64'h0000_1234_0000_0020);
      wr_cfg(32'h8);
      chk("R7 truncate", cmp_o, 64'h20);
      wr_cmp(1, 32'hFFFF);
      chk("R7 upper ignored", cmp_o, 64'h20);
      wr_cmp(0, 32'd5);
      cnt = 64'h0000_0005_0000_0003;
      wr_cfg(32'h9);
      step(); step();
      chk("R8 narrow sign", {63'd0, fire_o}, 64'd0);
      cnt = 64'h0000_0005_0000_0005; step();
      chk("R8 narrow match", {63'd0, fire_o}, 64'd1);
   endtask

   task automatic t_wrap();
      cnt = 64'h0000_0000_FFFF_FFFE;
      wr_cmp(0, 32'h10);
      step();
      cnt = 64'h0000_0000_FFFF_FFFF; step();
      chk("R9 before wrap", {63'd0, fire_o}, 64'd0);
      cnt = 64'h0000_0001_0000_0000; step();
      chk("R9 wrap fire", {63'd0, fire_o}, 64'd1);
      cnt = 64'h0000_0001_0000_0001; step();
      chk("R9 after wrap", {63'd0, fire_o}, 64'd0);
      cnt = 64'h0000_0001_0000_0010; step();
      chk("R9 match after wrap", {63'd0, fire_o}, 64'd1);
   endtask

   task automatic t_narrow_period();
      cnt = 64'h0000_0000_8000_0000;
      wr_cfg(32'hE);
      wr_cmp(0, 32'h8000_0005);
      wr_cfg(32'hB);
      cnt = 64'h0000_0000_8000_0005; step();
      chk("R6 narrow fire", {63'd0, fire_o}, 64'd1);
      chk("R6 narrow msb cleared", cmp_o, 64'h8000_000A);
   endtask

   task automatic t_arm();
      wr_cfg(32'h0);
      glb_en = 1'b0;
      wr_cmp(0, 32'h40);
      cnt = 64'h40;
      wr_cfg(32'h1);
      step(); step();
      chk("R10 global off", {63'd0, fire_o}, 64'd0);
      glb_en = 1'b1; step();
      chk("R10 arming edge", {63'd0, fire_o}, 64'd0);
      step();
      chk("R10 global rise arms", {63'd0, fire_o}, 64'd1);
      wr_cmp(0, 32'h50);
      wr_cfg(32'h0);
      cnt = 64'h50;
      step(); step();
      chk("R10 disarmed", {63'd0, fire_o}, 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R11 act=%0d exp=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      step(); step(); step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_oneshot();
      t_periodic();
      t_period_msb();
      t_narrow();
      t_wrap();
      t_narrow_period();
      t_arm();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule